// File: doc/BRIEF.md
# ATA Task-File Register Controller

This block is the device side of a single ATA disk as a host sees it through a narrow I/O window of eight offsets. It holds the sector-count, 24-bit LBA and device/head registers. It keeps the status register and raises an interrupt line. It also runs a small command sequencer. Byte writes land in the registers. A write to offset 7 issues a command. A read of offset 7 returns status and drops a pending interrupt.

Four opcodes are understood. IDENTIFY streams a 256-word information block through the 16-bit data port, and the block builds those words itself. FLUSH CACHE holds the device busy until a storage backend acknowledges. The two DMA opcodes latch the address and count, present them to a DMA engine through a request/done pair, and hold busy until that engine reports completion. Any other opcode is rejected with an error flag.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: Writes to offset 2 (count), 3, 4, 5 (LBA bits 7:0, 15:8, 23:16) and 6 (device/head) are read back unchanged at the same offset, in the low byte with the high byte zero. In the device register, bit 4 (0x10) selects device 1 and bit 6 (0x40) selects LBA mode, and both read back exactly as they were written.
- R2: Status at offset 7 uses bit 7 busy (0x80), bit 6 ready (0x40), bit 5 fault (0x20), bit 3 data request (0x08) and bit 0 error (0x01). Fault is always clear, and busy and data request are never set together.
- R3: After opcode 0xEC, status reads 0xC0 for one cycle and then 0x48. It stays 0x48 across 256 successive data-port reads. After the 256th read it reads 0x40.
- R4: In the identify block, words 10–19 carry the 20-character serial text and words 23–26 carry the 8-character revision text, each word holding its first character in bits 15:8. Word 85 has bit 5 set, and every other word reads zero.
- R5: After opcode 0xE7, flush_req is high and status reads 0xC0 until a one-cycle flush_ack. In the cycle after the ack, status reads 0x40 and flush_req is low.
- R6: Opcode 0xC8 raises dma_req with dma_to_host = 1, and opcode 0xCA raises it with dma_to_host = 0. dma_lba and dma_count hold the register values latched when the command was accepted, even if the registers are rewritten later. Status reads 0xC0 until dma_done, and 0x40 in the cycle after.
- R7: irq goes high in the cycle after a command completes. Completion means entering the identify data phase, a flush ack, a DMA done or a rejected opcode. A status read clears irq unless a completion happens in the same cycle.
- R8: A command write while busy is set has no effect on status, flush_req or dma_req.
- R9: Any opcode other than 0xC8, 0xCA, 0xE7 and 0xEC gives status 0x41 with busy clear and raises irq. The next accepted command clears the error bit.
- R10: After reset, status reads 0x40, all task-file registers read zero, and irq, flush_req and dma_req are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 3 | Register offset in the I/O window |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe; side effects take place at the clock edge |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 16 | Read data for the addressed offset, combinational |
| irq | output | 1 | Interrupt request |
| flush_req | output | 1 | Flush pending toward the backend |
| flush_ack | input | 1 | Backend reports the flush is finished |
| dma_req | output | 1 | DMA transfer pending |
| dma_to_host | output | 1 | 1 when data moves from disk to memory |
| dma_lba | output | 24 | Start LBA of the pending transfer |
| dma_count | output | 8 | Sector count of the pending transfer |
| dma_done | input | 1 | DMA engine reports completion |

## Verification
Some properties are checked by assertions on every cycle. These are that busy and data request never overlap, that a status read clears irq, and that command writes while busy leave the sequencer untouched. They also cover the error-and-interrupt response to a bad opcode, the latched DMA descriptor and the hold of a pending flush, and that the identify word counter moves only on a data read. Other behaviour can only be shown by the bench's scenarios. That includes the exact content of all 256 identify words, the status sequence seen through the port across a whole identify stream, and the readback of randomly written task-file registers. It also includes the direction and address presented for random DMA commands, and recovery from random illegal opcodes.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    localparam int LBA_W = 24;

    localparam logic [2:0] OFS_DATA    = 3'd0;
    localparam logic [2:0] OFS_COUNT   = 3'd2;
    localparam logic [2:0] OFS_LBA0    = 3'd3;
    localparam logic [2:0] OFS_LBA1    = 3'd4;
    localparam logic [2:0] OFS_LBA2    = 3'd5;
    localparam logic [2:0] OFS_DEVICE  = 3'd6;
    localparam logic [2:0] OFS_CMDSTAT = 3'd7;

    localparam logic [7:0] OP_RD_DMA = 8'hC8;
    localparam logic [7:0] OP_WR_DMA = 8'hCA;
    localparam logic [7:0] OP_FLUSH  = 8'hE7;
    localparam logic [7:0] OP_IDENT  = 8'hEC;

    // field order matches the bit positions the host decodes
    typedef struct packed {
        logic bsy;
        logic drdy;
        logic df;
        logic rsv4;
        logic drq;
        logic rsv2;
        logic rsv1;
        logic err;
    } tf_status_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ID_PREP,
        SQ_ID_XFER,
        SQ_FLUSH,
        SQ_DMA
    } seq_state_t;

    typedef enum logic [1:0] {
        CK_IDENT,
        CK_FLUSH,
        CK_DMA,
        CK_BAD
    } cmd_kind_t;

    typedef struct packed {
        logic             to_host;
        logic [LBA_W-1:0] lba;
        logic [7:0]       count;
    } dma_desc_t;

    function automatic cmd_kind_t classify(input logic [7:0] op);
        cmd_kind_t k;
        case (op)
            OP_IDENT:             k = CK_IDENT;
            OP_FLUSH:             k = CK_FLUSH;
            OP_RD_DMA, OP_WR_DMA: k = CK_DMA;
            default:              k = CK_BAD;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
    import ata_tf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       count,
    output logic [LBA_W-1:0] lba,
    output logic [7:0]       device
);

    localparam int LBA_BYTES = LBA_W / 8;

    logic [7:0] lba_byte [LBA_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            device <= '0;
        end else if (wr_en) begin
            if (addr == OFS_COUNT)  count  <= wdata;
            if (addr == OFS_DEVICE) device <= wdata;
        end
    end

    for (genvar b = 0; b < LBA_BYTES; b++) begin : g_lba
        localparam logic [2:0] MY_OFS = OFS_LBA0 + 3'(b);
        always_ff @(posedge clk) begin
            if (rst)                            lba_byte[b] <= '0;
            else if (wr_en && addr == MY_OFS)   lba_byte[b] <= wdata;
        end
        assign lba[8*b +: 8] = lba_byte[b];

        // R1: a write elsewhere never disturbs this byte
        assert_lba_byte_hold_R1: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && addr == MY_OFS) |=> $stable(lba_byte[b]));
    end

endmodule

// File: rtl/ata_tf_ident.sv
module ata_tf_ident #(
    parameter int ID_WORDS     = 256,
    parameter int SERIAL_LEN   = 20,
    parameter int REV_LEN      = 8,
    parameter int SERIAL_WORD  = 10,
    parameter int REV_WORD     = 23,
    parameter int CACHE_WORD   = 85,
    parameter int CACHE_BIT    = 5,
    parameter logic [8*SERIAL_LEN-1:0] SERIAL_TEXT = "testdisk            ",
    parameter logic [8*REV_LEN-1:0]    REV_TEXT    = "version "
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        advance,
    output logic [15:0] word,
    output logic        last
);

    localparam int IDX_W = $clog2(ID_WORDS);

    logic [IDX_W-1:0] idx_q;

    // first character of each pair goes to the high byte
    function automatic logic [15:0] word_at(input logic [IDX_W-1:0] i);
        logic [15:0] w;
        int ii;
        int k;
        w  = '0;
        ii = int'(i);
        if (ii >= SERIAL_WORD && ii < SERIAL_WORD + SERIAL_LEN / 2) begin
            k = 2 * (ii - SERIAL_WORD);
            w = {SERIAL_TEXT[8*(SERIAL_LEN-1-k) +: 8],
                 SERIAL_TEXT[8*(SERIAL_LEN-2-k) +: 8]};
        end else if (ii >= REV_WORD && ii < REV_WORD + REV_LEN / 2) begin
            k = 2 * (ii - REV_WORD);
            w = {REV_TEXT[8*(REV_LEN-1-k) +: 8],
                 REV_TEXT[8*(REV_LEN-2-k) +: 8]};
        end else if (ii == CACHE_WORD) begin
            w[CACHE_BIT] = 1'b1;
        end
        return w;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || start) idx_q <= '0;
        else if (advance) idx_q <= idx_q + 1'b1;
    end

    assign word = word_at(idx_q);
    assign last = (idx_q == IDX_W'(ID_WORDS - 1));

    // R3: the stream position moves only on a data read or a restart
    assert_idx_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!advance && !start) |=> $stable(idx_q));

endmodule

// File: rtl/ata_tf_seq.sv
module ata_tf_seq
    import ata_tf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [7:0]       cmd_op,
    input  logic             status_rd,
    input  logic             id_adv,
    input  logic             id_last,
    input  logic             flush_ack,
    input  logic             dma_done,
    input  logic [7:0]       count,
    input  logic [LBA_W-1:0] lba,
    output tf_status_t       status,
    output logic             irq,
    output logic             id_start,
    output logic             flush_req,
    output logic             dma_req,
    output dma_desc_t        desc
);

    seq_state_t state_q;
    logic       err_q;
    logic       irq_q;
    dma_desc_t  desc_q;
    cmd_kind_t  kind;
    logic       busy;
    logic       accept;
    logic       done_evt;

    assign kind   = classify(cmd_op);
    assign busy   = (state_q == SQ_ID_PREP) || (state_q == SQ_FLUSH) || (state_q == SQ_DMA);
    assign accept = cmd_wr && !busy;

    always_comb begin
        done_evt = 1'b0;
        case (state_q)
            SQ_ID_PREP: done_evt = 1'b1;
            SQ_FLUSH:   done_evt = flush_ack;
            SQ_DMA:     done_evt = dma_done;
            default:    done_evt = accept && (kind == CK_BAD);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            err_q   <= 1'b0;
            irq_q   <= 1'b0;
            desc_q  <= '0;
        end else begin
            if (done_evt)       irq_q <= 1'b1;
            else if (status_rd) irq_q <= 1'b0;

            case (state_q)
                SQ_ID_PREP: state_q <= SQ_ID_XFER;
                SQ_ID_XFER: if (id_adv && id_last) state_q <= SQ_IDLE;
                SQ_FLUSH:   if (flush_ack) state_q <= SQ_IDLE;
                SQ_DMA:     if (dma_done)  state_q <= SQ_IDLE;
                default:    state_q <= SQ_IDLE;
            endcase

            if (accept) begin
                err_q <= (kind == CK_BAD);
                case (kind)
                    CK_IDENT: state_q <= SQ_ID_PREP;
                    CK_FLUSH: state_q <= SQ_FLUSH;
                    CK_DMA: begin
                        state_q        <= SQ_DMA;
                        desc_q.to_host <= (cmd_op == OP_RD_DMA);
                        desc_q.lba     <= lba;
                        desc_q.count   <= count;
                    end
                    default:  state_q <= SQ_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        status      = '0;
        status.bsy  = busy;
        status.drdy = 1'b1;
        status.drq  = (state_q == SQ_ID_XFER);
        status.err  = err_q;
    end

    assign irq       = irq_q;
    assign id_start  = accept && (kind == CK_IDENT);
    assign flush_req = (state_q == SQ_FLUSH);
    assign dma_req   = (state_q == SQ_DMA);
    assign desc      = desc_q;

    assert_bsy_drq_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(status.bsy && status.drq) && !status.df);

    assert_irq_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !done_evt) |=> !irq);

    assert_busy_cmd_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_wr && !done_evt) |=> ($stable(state_q) && $stable(err_q)));

    assert_bad_op_R9: assert property (@(posedge clk) disable iff (rst)
        (accept && kind == CK_BAD) |=> (err_q && irq && !busy));

    assert_flush_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (flush_req && !flush_ack) |=> (flush_req && status.bsy));

    assert_dma_desc_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (dma_req && !dma_done) |=> (dma_req && $stable(desc_q)));

    assert_ident_end_R3: assert property (@(posedge clk) disable iff (rst)
        (status.drq && id_adv && id_last && !cmd_wr) |=> (!status.drq && !busy));

endmodule

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl
    import ata_tf_pkg::*;
#(
    parameter int ID_WORDS   = 256,
    parameter int SERIAL_LEN = 20,
    parameter int REV_LEN    = 8,
    parameter logic [8*SERIAL_LEN-1:0] SERIAL_TEXT = "testdisk            ",
    parameter logic [8*REV_LEN-1:0]    REV_TEXT    = "version "
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [7:0]  io_wdata,
    output logic [15:0] io_rdata,
    output logic        irq,
    output logic        flush_req,
    input  logic        flush_ack,
    output logic        dma_req,
    output logic        dma_to_host,
    output logic [23:0] dma_lba,
    output logic [7:0]  dma_count,
    input  logic        dma_done
);

    logic [7:0]       r_count;
    logic [LBA_W-1:0] r_lba;
    logic [7:0]       r_device;
    tf_status_t       status;
    dma_desc_t        desc;
    logic             id_start;
    logic             id_adv;
    logic             id_last;
    logic [15:0]      id_word;
    logic             cmd_wr;
    logic             status_rd;

    assign cmd_wr    = io_wr && (io_addr == OFS_CMDSTAT);
    assign status_rd = io_rd && (io_addr == OFS_CMDSTAT);
    assign id_adv    = io_rd && (io_addr == OFS_DATA) && status.drq;

    ata_tf_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (io_wr),
        .addr   (io_addr),
        .wdata  (io_wdata),
        .count  (r_count),
        .lba    (r_lba),
        .device (r_device)
    );

    ata_tf_ident #(
        .ID_WORDS    (ID_WORDS),
        .SERIAL_LEN  (SERIAL_LEN),
        .REV_LEN     (REV_LEN),
        .SERIAL_TEXT (SERIAL_TEXT),
        .REV_TEXT    (REV_TEXT)
    ) u_ident (
        .clk     (clk),
        .rst     (rst),
        .start   (id_start),
        .advance (id_adv),
        .word    (id_word),
        .last    (id_last)
    );

    ata_tf_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr    (cmd_wr),
        .cmd_op    (io_wdata),
        .status_rd (status_rd),
        .id_adv    (id_adv),
        .id_last   (id_last),
        .flush_ack (flush_ack),
        .dma_done  (dma_done),
        .count     (r_count),
        .lba       (r_lba),
        .status    (status),
        .irq       (irq),
        .id_start  (id_start),
        .flush_req (flush_req),
        .dma_req   (dma_req),
        .desc      (desc)
    );

    always_comb begin
        case (io_addr)
            OFS_DATA:    io_rdata = status.drq ? id_word : 16'h0000;
            OFS_COUNT:   io_rdata = {8'h00, r_count};
            OFS_LBA0:    io_rdata = {8'h00, r_lba[7:0]};
            OFS_LBA1:    io_rdata = {8'h00, r_lba[15:8]};
            OFS_LBA2:    io_rdata = {8'h00, r_lba[23:16]};
            OFS_DEVICE:  io_rdata = {8'h00, r_device};
            OFS_CMDSTAT: io_rdata = {8'h00, status};
            default:     io_rdata = 16'h0000;
        endcase
    end

    assign dma_to_host = desc.to_host;
    assign dma_lba     = desc.lba;
    assign dma_count   = desc.count;

    // R6: the DMA request and the flush request are never pending together
    assert_single_job_R6: assert property (@(posedge clk) disable iff (rst)
        !(dma_req && flush_req));

endmodule

// File: tb/ata_taskfile_ctrl_tb.sv
module ata_taskfile_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam string SER_T = "testdisk            ";
    localparam string REV_T = "version ";

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [15:0] io_rdata;
    logic        irq;
    logic        flush_req;
    logic        flush_ack = 1'b0;
    logic        dma_req;
    logic        dma_to_host;
    logic [23:0] dma_lba;
    logic [7:0]  dma_count;
    logic        dma_done = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_taskfile_ctrl u_dut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .irq(irq),
        .flush_req(flush_req), .flush_ack(flush_ack), .dma_req(dma_req),
        .dma_to_host(dma_to_host), .dma_lba(dma_lba), .dma_count(dma_count),
        .dma_done(dma_done)
    );

    function automatic logic [15:0] exp_word(input int i);
        logic [15:0] w = 16'h0000;
        if (i >= 10 && i < 20) w = {8'(SER_T[2*(i-10)]), 8'(SER_T[2*(i-10)+1])};
        else if (i >= 23 && i < 27) w = {8'(REV_T[2*(i-23)]), 8'(REV_T[2*(i-23)+1])};
        else if (i == 85) w = 16'h0020;
        return w;
    endfunction

    function automatic bit known_op(input logic [7:0] op);
        return op == 8'hC8 || op == 8'hCA || op == 8'hE7 || op == 8'hEC;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        @(posedge clk); @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic pulse_flush_ack();
        flush_ack = 1'b1; @(posedge clk); @(negedge clk); flush_ack = 1'b0;
    endtask

    task automatic pulse_dma_done();
        dma_done = 1'b1; @(posedge clk); @(negedge clk); dma_done = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'h5eed_a7a0));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        rd(3'd7, v); chk("R10 status", v, 16'h0040);
        chk("R10 irq", irq, 0);
        chk("R10 flush_req", flush_req, 0);
        chk("R10 dma_req", dma_req, 0);
        for (int a = 2; a <= 6; a++) begin
            rd(3'(a), v); chk("R10 reg zero", v, 0);
        end

        // R1: random register readback
        for (int n = 0; n < 20; n++) begin
            logic [7:0] vals [2:6];
            for (int a = 2; a <= 6; a++) begin
                vals[a] = 8'($urandom);
                wr(3'(a), vals[a]);
            end
            for (int a = 2; a <= 6; a++) begin
                rd(3'(a), v); chk("R1 readback", v, {8'h00, vals[a]});
            end
        end
        wr(3'd6, 8'h50); rd(3'd6, v); chk("R1 device1 bit", v, 16'h0050);

        // R3 R4 R7: identify stream on device 0
        wr(3'd6, 8'h40);
        wr(3'd7, 8'hEC);
        rd(3'd7, v); chk("R3 preparing", v, 16'h00C0);
        chk("R7 irq on data ready", irq, 1);
        rd(3'd7, v); chk("R3 drq", v, 16'h0048);
        chk("R7 irq cleared by status read", irq, 0);
        for (int i = 0; i < 256; i++) begin
            rd(3'd7, v); chk("R3 drq during stream", v, 16'h0048);
            rd(3'd0, v); chk("R4 identify word", v, exp_word(i));
        end
        rd(3'd7, v); chk("R3 after stream", v, 16'h0040);
        rd(3'd0, v); chk("R3 data port idle", v, 16'h0000);
        rd(3'd6, v); chk("R1 device0 reads back", v & 16'h0010, 16'h0000);

        // R5 R8: flush with a command written while busy
        wr(3'd7, 8'hE7);
        chk("R5 flush_req", flush_req, 1);
        rd(3'd7, v); chk("R5 busy", v, 16'h00C0);
        wr(3'd7, 8'hEC);
        rd(3'd7, v); chk("R8 ignored while busy", v, 16'h00C0);
        chk("R8 flush still pending", flush_req, 1);
        wr(3'd7, 8'h00);
        chk("R8 bad op ignored while busy", flush_req, 1);
        repeat (5) @(negedge clk);
        chk("R5 held until ack", flush_req, 1);
        pulse_flush_ack();
        chk("R5 flush_req dropped", flush_req, 0);
        chk("R7 irq on flush done", irq, 1);
        rd(3'd7, v); chk("R5 done status", v, 16'h0040);
        chk("R7 irq cleared", irq, 0);

        // R6: random DMA commands
        for (int n = 0; n < 12; n++) begin
            logic [23:0] l = 24'($urandom);
            logic [7:0]  c = 8'($urandom);
            bit          rdir = 1'($urandom);
            wr(3'd2, c); wr(3'd3, l[7:0]); wr(3'd4, l[15:8]); wr(3'd5, l[23:16]);
            wr(3'd7, rdir ? 8'hC8 : 8'hCA);
            chk("R6 dma_req", dma_req, 1);
            chk("R6 direction", dma_to_host, rdir);
            chk("R6 lba", dma_lba, l);
            chk("R6 count", dma_count, c);
            rd(3'd7, v); chk("R6 busy", v, 16'h00C0);
            wr(3'd3, ~l[7:0]); wr(3'd2, ~c);
            chk("R6 lba latched", dma_lba, l);
            chk("R6 count latched", dma_count, c);
            wr(3'd7, 8'hE7);
            chk("R8 no flush while dma", flush_req, 0);
            pulse_dma_done();
            chk("R6 dma_req dropped", dma_req, 0);
            chk("R7 irq on dma done", irq, 1);
            rd(3'd7, v); chk("R6 done status", v, 16'h0040);
            chk("R7 irq cleared after dma", irq, 0);
        end

        // R9: random illegal opcodes
        for (int n = 0; n < 10; n++) begin
            logic [7:0] op;
            do op = 8'($urandom); while (known_op(op));
            wr(3'd7, op);
            chk("R9 irq", irq, 1);
            chk("R9 no request", {flush_req, dma_req}, 0);
            rd(3'd7, v); chk("R9 error status", v, 16'h0041);
            chk("R9 irq cleared", irq, 0);
        end
        wr(3'd7, 8'hE7);
        rd(3'd7, v); chk("R9 error cleared by next command", v, 16'h00C0);
        pulse_flush_ack();
        rd(3'd7, v); chk("R9 clean finish", v, 16'h0040);

        summary();
    end

endmodule